// File: doc/BRIEF.md
# Rolling-Readout Sensor Timing Generator

This block produces the free-running readout timing of a rolling-readout image sensor operating as timing master. From one system clock it drives a frame envelope, a row envelope inside it, an 8-bit pixel stream and an exposure indicator. The pixel values are a running test-pattern index, so a receiver or a bench can predict every sample.

Each row is a fixed line of `LEAD + COLS + TAIL` clocks: a lead cycle, the active columns, then a low tail. With the defaults that is 1 + 666 + 4 = 671 clocks, and a frame holds 502 rows with no added blanking. The integration time is given in rows. Exposure for the following frame runs alongside the current readout. A new frame starts only after the current readout, a programmable idle gap and the running exposure have all finished. A long exposure therefore sets the frame period.

The frame envelope and the exposure indicator are launched on rising clock edges. The row envelope and the pixel data are launched on falling edges, which places the first row half a clock off the frame grid.

Top module: `sensor_readout_gen`

## Requirements
- R1: While `rst` is high, all outputs are low and `pix_data` is zero.
- R2: Every row takes `LEAD+COLS+TAIL` clocks. In each row `row_valid` is high for exactly `COLS` clocks and low for the rest, and each frame contains exactly `ROWS` row pulses.
- R3: `row_valid` rises for the first row `LEAD+1.5` clocks after `frame_valid` rises, which is 2.5 clocks at the default lead of 1.
- R4: `frame_valid` stays high for exactly `ROWS*(LEAD+COLS+TAIL)` clocks. It falls `TAIL-1.5` clocks after the last row's `row_valid` falls, which is 2.5 clocks at the default tail of 4.
- R5: `frame_valid` and `expose` change only on rising clock edges. `row_valid` and `pix_data` change only on falling clock edges.
- R6: While `row_valid` is high, `pix_data` carries the pixel's index within its frame (row times `COLS` plus column, counted from 0) modulo 2^`PIX_W`. While `row_valid` is low, `pix_data` is zero.
- R7: `expose` rises with `frame_valid` and stays high for `integ_rows*(LEAD+COLS+TAIL)` clocks. An `integ_rows` of 0 keeps it low.
- R8: The first frame starts on the first rising edge after reset is released. The next frame starts `max(readout + gap, exposure)` clocks later, where gap is the idle cycle count in R9.
- R9: `frame_valid` stays low for at least `idle_gap` clocks between frames. A value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| integ_rows | input | IW | Integration time in row units, sampled at each frame start |
| idle_gap | input | GW | Minimum frame_valid low cycles between frames (0 acts as 1) |
| frame_valid | output | 1 | Frame envelope, rising-edge launched |
| row_valid | output | 1 | Row envelope, falling-edge launched |
| pix_data | output | PIX_W | Test-pattern pixel value, falling-edge launched |
| expose | output | 1 | High during the programmed integration time |

## Verification
The end of the exposure and the end of the idle gap can fall in the same cycle. Both conditions then release the next frame together, and the new frame start reloads the exposure counter on the cycle its old count runs out. The bench provokes this with an integration of 41 rows against a 40-row readout plus a 13-cycle gap, so both limits equal 533 clocks. It judges the case by the measured start-to-start period and by a per-half-cycle comparison with a behavioural model. Separate runs put the exposure well below and well above the readout, so each limit alone sets the period.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic [1:0] {
    SEQ_WAIT = 2'd0,
    SEQ_READ = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/srg_line_counter.sv
module srg_line_counter #(
  parameter int COLS  = 666,
  parameter int ROWS  = 502,
  parameter int LEAD  = 1,
  parameter int TAIL  = 4,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             run_i,
  output logic             last_o,
  output logic             act_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int LINE_LEN = LEAD + COLS + TAIL;
  localparam int CW = $clog2(LINE_LEN + 1);
  localparam int RW = $clog2(ROWS + 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(LINE_LEN - 1);
  localparam logic [CW-1:0] COL_FIRST = CW'(LEAD);
  localparam logic [CW-1:0] COL_END   = CW'(LEAD + COLS - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

  logic [CW-1:0]    col;
  logic [RW-1:0]    row;
  logic [PIX_W-1:0] pidx;

  assign act_o  = run_i && (col >= COL_FIRST) && (col <= COL_END);
  assign last_o = run_i && (col == COL_LAST) && (row == ROW_LAST);
  assign pix_o  = act_o ? pidx : '0;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      col  <= '0;
      row  <= '0;
      pidx <= '0;
    end else if (run_i) begin
      if (col == COL_LAST) begin
        col <= '0;
        row <= row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
      if (act_o) pidx <= pidx + PIX_W'(1);
    end
  end

  // R2: the column position never leaves the line
  a_r2_col_in_line: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (col <= COL_LAST));
endmodule

// File: rtl/srg_expose_timer.sv
module srg_expose_timer #(
  parameter int IW       = 16,
  parameter int LINE_LEN = 671
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [IW-1:0] integ_i,
  output logic          expose_o,
  output logic          done_o
);
  localparam int EW = IW + $clog2(LINE_LEN + 1);

  logic [EW-1:0] cnt;

  assign expose_o = (cnt != '0);
  assign done_o   = (cnt <= EW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= EW'(integ_i) * EW'(LINE_LEN);
    end else if (cnt != '0) begin
      cnt <= cnt - EW'(1);
    end
  end

  // R7: a zero integration time never raises the indicator
  a_r7_zero_integ_stays_low: assert property (@(posedge clk) disable iff (rst)
    (load_i && (integ_i == '0)) |=> !expose_o);
endmodule

// File: rtl/srg_sequencer.sv
module srg_sequencer
  import srg_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          last_i,
  input  logic          exp_done_i,
  input  logic [GW-1:0] idle_i,
  output logic          start_o,
  output logic          read_o
);
  seq_state_t    state;
  logic [GW-1:0] gcnt;

  assign start_o = exp_done_i &&
                   ((state == SEQ_WAIT) || ((state == SEQ_GAP) && (gcnt == '0)));
  assign read_o  = (state == SEQ_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_WAIT;
      gcnt  <= '0;
    end else begin
      case (state)
        SEQ_WAIT: if (start_o) state <= SEQ_READ;
        SEQ_READ: if (last_i) begin
          state <= SEQ_GAP;
          gcnt  <= (idle_i == '0) ? '0 : idle_i - GW'(1);
        end
        SEQ_GAP: begin
          if (gcnt == '0) state <= exp_done_i ? SEQ_READ : SEQ_WAIT;
          else            gcnt  <= gcnt - GW'(1);
        end
        default: state <= SEQ_WAIT;
      endcase
    end
  end

  // R4: the frame envelope ends only after the last line position
  a_r4_frame_ends_at_last: assert property (@(posedge clk) disable iff (rst)
    $fell(read_o) |-> $past(last_i));
  // R8: no frame starts while the exposure is still running
  a_r8_start_waits_exposure: assert property (@(posedge clk) disable iff (rst)
    start_o |-> exp_done_i);
endmodule

// File: rtl/sensor_readout_gen.sv
module sensor_readout_gen #(
  parameter int COLS  = 666,
  parameter int ROWS  = 502,
  parameter int LEAD  = 1,
  parameter int TAIL  = 4,
  parameter int PIX_W = 8,
  parameter int IW    = 16,
  parameter int GW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    integ_rows,
  input  logic [GW-1:0]    idle_gap,
  output logic             frame_valid,
  output logic             row_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             expose
);
  localparam int LINE_LEN = LEAD + COLS + TAIL;

  logic             start, last, act, exp_done;
  logic [PIX_W-1:0] pix_c;
  logic             rv_pre;
  logic [PIX_W-1:0] pix_pre;

  srg_sequencer #(.GW(GW)) u_seq (
    .clk(clk), .rst(rst), .last_i(last), .exp_done_i(exp_done),
    .idle_i(idle_gap), .start_o(start), .read_o(frame_valid)
  );

  srg_line_counter #(.COLS(COLS), .ROWS(ROWS), .LEAD(LEAD), .TAIL(TAIL), .PIX_W(PIX_W)) u_line (
    .clk(clk), .rst(rst), .start_i(start), .run_i(frame_valid),
    .last_o(last), .act_o(act), .pix_o(pix_c)
  );

  srg_expose_timer #(.IW(IW), .LINE_LEN(LINE_LEN)) u_exp (
    .clk(clk), .rst(rst), .load_i(start), .integ_i(integ_rows),
    .expose_o(expose), .done_o(exp_done)
  );

  // rising-edge stage: one clock of alignment before the falling-edge launch
  always_ff @(posedge clk) begin
    if (rst) begin
      rv_pre  <= 1'b0;
      pix_pre <= '0;
    end else begin
      rv_pre  <= act;
      pix_pre <= pix_c;
    end
  end

  // falling-edge launch of the row envelope and pixel data
  always_ff @(negedge clk) begin
    if (rst) begin
      row_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      row_valid <= rv_pre;
      pix_data  <= pix_pre;
    end
  end

  // R2: rows stay inside the frame envelope
  a_r2_row_inside_frame: assert property (@(posedge clk) disable iff (rst)
    rv_pre |-> frame_valid);
  // R6: data is blank between rows
  a_r6_blank_between_rows: assert property (@(posedge clk) disable iff (rst)
    !rv_pre |-> (pix_pre == '0));
  // R3: no row is pending on the edge that opens a frame
  a_r3_no_row_at_frame_open: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_valid) |-> !rv_pre);
endmodule

// File: tb/test_sensor_readout_gen.sv
`timescale 1ns/1ps
module test_sensor_readout_gen;
  localparam int COLS = 8, ROWS = 40, LEAD = 1, TAIL = 4, PIX_W = 8, IW = 8, GW = 8;
  localparam int L = LEAD + COLS + TAIL;
  localparam int R = ROWS * L;
  localparam int CYCLE_LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] integ_rows = '0;
  logic [GW-1:0] idle_gap = '0;
  logic frame_valid, row_valid, expose;
  logic [PIX_W-1:0] pix_data;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  sensor_readout_gen #(.COLS(COLS), .ROWS(ROWS), .LEAD(LEAD), .TAIL(TAIL),
                       .PIX_W(PIX_W), .IW(IW), .GW(GW)) i_sensor_readout_gen (
    .clk(clk), .rst(rst), .integ_rows(integ_rows), .idle_gap(idle_gap),
    .frame_valid(frame_valid), .row_valid(row_valid), .pix_data(pix_data), .expose(expose)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int period_of(int integ, int idle);
    int g = (idle == 0) ? 1 : idle;
    int x = integ * L;
    return (x > R + g) ? x : R + g;
  endfunction

  // behavioural reference: frame starts, expected envelopes per clock interval
  int cyc = -1, s_at = 0, nxt = 0, x_len = 0;
  int e_fv = 0, e_ex = 0;
  int c0_rv = 0, c1_rv = 0, c2_rv = 0, c0_px = 0, c1_px = 0, c2_px = 0;

  always @(posedge clk) begin
    if (rst) begin
      cyc = -1; s_at = 0; nxt = 0; x_len = 0; e_fv = 0; e_ex = 0;
      c0_rv = 0; c1_rv = 0; c2_rv = 0; c0_px = 0; c1_px = 0; c2_px = 0;
    end else begin
      int t, col, row, act;
      cyc++;
      if (cyc == nxt) begin
        s_at  = cyc;
        x_len = int'(integ_rows) * L;
        nxt   = cyc + period_of(int'(integ_rows), int'(idle_gap));
      end
      t = cyc - s_at;
      col = t % L;
      row = t / L;
      e_fv = (t < R) ? 1 : 0;
      e_ex = (t < x_len) ? 1 : 0;
      act = (e_fv == 1 && col >= LEAD && col < LEAD + COLS) ? 1 : 0;
      c2_rv = c1_rv; c1_rv = c0_rv; c0_rv = act;
      c2_px = c1_px; c1_px = c0_px;
      c0_px = act ? ((row * COLS + col - LEAD) % (1 << PIX_W)) : 0;
    end
  end

  // measurements on the ports
  int prev_fv = 0, prev_rv = 0, fv_rise_at = -1, rows_seen = 0, rv_run = 0, last_rv_fall = -1;

  task automatic clear_meas();
    prev_fv = 0; prev_rv = 0; fv_rise_at = -1; rows_seen = 0; rv_run = 0; last_rv_fall = -1;
  endtask

  task automatic sample_rise_half();
    if (rst || cyc < 0) begin clear_meas(); return; end
    chk("R4", "frame_valid vs model", int'(frame_valid), e_fv);
    chk("R7", "expose vs model", int'(expose), e_ex);
    chk("R5", "row_valid before falling edge", int'(row_valid), c2_rv);
    chk("R6", "pix_data before falling edge", int'(pix_data), c2_px);
    if (!prev_fv && frame_valid) begin
      if (fv_rise_at >= 0) begin
        chk((idle_gap == 0) ? "R9" : "R8", "frame period",
            cyc - fv_rise_at, period_of(int'(integ_rows), int'(idle_gap)));
        chk("R2", "rows per frame", rows_seen, ROWS);
      end
      fv_rise_at = cyc;
      rows_seen = 0;
    end
    if (prev_fv && !frame_valid)
      chk("R4", "frame_valid fall after last row fall", cyc - last_rv_fall, TAIL - 1);
    prev_fv = int'(frame_valid);
  endtask

  task automatic sample_fall_half();
    if (rst || cyc < 0) begin clear_meas(); return; end
    chk("R5", "row_valid after falling edge", int'(row_valid), c1_rv);
    chk("R6", "pix_data after falling edge", int'(pix_data), c1_px);
    if (!prev_rv && row_valid) begin
      if (rows_seen == 0 && fv_rise_at >= 0)
        chk("R3", "first row_valid rise offset", cyc - fv_rise_at, LEAD + 1);
      rows_seen++;
      rv_run = 0;
    end
    if (row_valid) rv_run++;
    if (prev_rv && !row_valid) begin
      chk("R2", "row_valid high length", rv_run, COLS);
      last_rv_fall = cyc;
    end
    prev_rv = int'(row_valid);
  endtask

  initial begin
    forever begin
      @(posedge clk); #5; sample_rise_half();
      @(negedge clk); #5; sample_fall_half();
    end
  end

  task automatic run_phase(int integ, int idle, int frames);
    @(posedge clk); #2;
    rst = 1'b1;
    integ_rows = IW'(integ);
    idle_gap = GW'(idle);
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "frame_valid in reset", int'(frame_valid), 0);
    chk("R1", "row_valid in reset", int'(row_valid), 0);
    chk("R1", "pix_data in reset", int'(pix_data), 0);
    chk("R1", "expose in reset", int'(expose), 0);
    @(posedge clk); #2;
    rst = 1'b0;
    repeat (frames * period_of(integ, idle) + 10) @(posedge clk);
  endtask

  initial begin
    run_phase(0, 3, 3);    // R7: no exposure, readout plus gap sets the period
    run_phase(10, 0, 3);   // R9: zero gap acts as one, short exposure
    run_phase(50, 1, 3);   // R8: exposure longer than readout stretches the period
    run_phase(41, 13, 3);  // R8: exposure end and gap end coincide
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CYCLE_LIMIT * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule